// File: doc/BRIEF.md
# Capability list walker

This engine searches the chain of capability blocks kept in a device configuration header for one capability ID. A single start pulse with a target ID launches a walk. The engine fetches bytes one at a time from a 256-byte configuration space through a read port: a one-cycle request with an address, then a valid strobe with the data after any latency. It first checks the status byte to see whether a chain exists, then follows pointers from block to block until it finds the ID, reaches the end of the chain, or meets a chain that cannot be valid.

At the end of every walk a one-cycle done pulse is raised. The found flag, the byte offset of the matching block and a two-bit error code are registered and held until the next walk begins. Pointers have their two reserved low bits cleared before use. A non-zero pointer into the fixed header region is reported as an illegal pointer, and a chain longer than the number of aligned block positions is reported as a loop.

Top module: `cap_walker`

## Requirements
- R1: After reset, done, found, rd_req, err (code 2'b00) and offset (0x00) are all zero.
- R2: The first read of a walk is the byte at 0x06. If bit 4 of that byte is clear, the walk ends with found=0 and err=2'b00, and no other read is made.
- R3: The head pointer is the byte at 0x34. Every pointer, head or next, has its bits 1:0 cleared before it is used as a block offset.
- R4: A block at offset p holds its ID at p and its next pointer at p+1. When the ID equals target_id, the walk ends with found=1, err=2'b00 and offset=p. This covers any ID value, for example 0x01, 0x05 and 0x07.
- R5: A pointer that masks to zero ends the walk with found=0, err=2'b00 and offset=0x00.
- R6: A pointer that masks to a non-zero value below 0x40 ends the walk with found=0 and err=2'b01 (illegal pointer).
- R7: At most 48 blocks are visited in one walk. A further non-zero legal pointer after 48 blocks ends the walk with found=0 and err=2'b10 (loop). A chain of exactly 48 blocks is walked in full without error.
- R8: done is high for exactly one cycle per walk. found, offset and err stay stable from that pulse until the next accepted start.
- R9: start is taken only while the engine is idle. A start pulse during a walk, along with the target_id present at that time, has no effect on the walk in progress, and it produces no second done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| target_id | input | 8 | Capability ID to search for |
| rd_req | output | 1 | One-cycle configuration byte read request |
| rd_addr | output | 8 | Byte address of the read |
| rd_valid | input | 1 | Read data valid strobe |
| rd_data | input | 8 | Read data byte |
| done | output | 1 | One-cycle end-of-walk pulse |
| found | output | 1 | Target ID was located |
| offset | output | 8 | Offset of the matching block, else 0 |
| err | output | 2 | 00 none, 01 illegal pointer, 10 loop |

## Verification
The hardest condition to reach from the ports is the hop limit: it needs a chain that is well-formed at every step yet never ends. The bench builds two configuration images for it. The first is a block whose next pointer points back to itself, which must give the loop code. The second fills every aligned position from 0x40 to 0xFC in order with the target in the last one, which must be found with no error, so the limit is shown to sit exactly at 48. Pointers with reserved bits set are placed both in the head and in a next field. These show that masking is applied to every pointer and not only the first.

// File: rtl/cap_walk_pkg.sv
package cap_walk_pkg;
  typedef enum logic [1:0] {
    ERR_NONE = 2'b00,
    ERR_BAD  = 2'b01,
    ERR_LOOP = 2'b10
  } walk_err_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_STAT = 2'd1,
    S_PTR  = 2'd2,
    S_ID   = 2'd3
  } walk_state_t;
endpackage

// File: rtl/cw_ptr_check.sv
module cw_ptr_check #(
  parameter int AW        = 8,
  parameter int RSVD_BITS = 2,
  parameter int MIN_PTR   = 'h40
) (
  input  logic [AW-1:0] raw,
  output logic [AW-1:0] masked,
  output logic          is_end,
  output logic          is_bad
);
  localparam logic [AW-1:0] KEEP = ~((AW'(1) << RSVD_BITS) - AW'(1));
  localparam logic [AW-1:0] LOW  = AW'(MIN_PTR);

  always_comb begin
    masked = raw & KEEP;
    is_end = (masked == '0);
    is_bad = !is_end && (masked < LOW);
  end
endmodule

// File: rtl/cw_hop_ctr.sv
module cw_hop_ctr #(
  parameter int MAX_HOPS = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_HOPS + 1);
  localparam logic [CW-1:0] LIM = CW'(MAX_HOPS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && cnt != LIM) cnt <= cnt + CW'(1);
  end

  assign at_limit = (cnt == LIM);

  // R7: the number of visited blocks never passes the limit
  a_r7_hop_bound: assert property (@(posedge clk) disable iff (rst)
    inc |=> (cnt <= LIM));
endmodule

// File: rtl/cap_walker.sv
module cap_walker
  import cap_walk_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int STAT_ADDR = 'h06,
  parameter int STAT_BIT  = 4,
  parameter int HEAD_ADDR = 'h34,
  parameter int MIN_PTR   = 'h40,
  parameter int RSVD_BITS = 2,
  parameter int MAX_HOPS  = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] target_id,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          done,
  output logic          found,
  output logic [AW-1:0] offset,
  output logic [1:0]    err
);
  localparam logic [AW-1:0] A_STAT = AW'(STAT_ADDR);
  localparam logic [AW-1:0] A_HEAD = AW'(HEAD_ADDR);

  walk_state_t   state;
  logic [DW-1:0] target_q;
  logic [AW-1:0] cur;
  logic [AW-1:0] p_masked;
  logic          p_end, p_bad;
  logic          at_limit;
  logic          hop_clr, hop_inc;

  cw_ptr_check #(.AW(AW), .RSVD_BITS(RSVD_BITS), .MIN_PTR(MIN_PTR)) u_pchk (
    .raw    (rd_data[AW-1:0]),
    .masked (p_masked),
    .is_end (p_end),
    .is_bad (p_bad)
  );

  cw_hop_ctr #(.MAX_HOPS(MAX_HOPS)) u_hops (
    .clk      (clk),
    .rst      (rst),
    .clr      (hop_clr),
    .inc      (hop_inc),
    .at_limit (at_limit)
  );

  always_comb begin
    hop_clr = (state == S_IDLE) && start;
    hop_inc = (state == S_PTR) && rd_valid && !p_end && !p_bad && !at_limit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      target_q <= '0;
      cur      <= '0;
      rd_req   <= 1'b0;
      rd_addr  <= '0;
      done     <= 1'b0;
      found    <= 1'b0;
      offset   <= '0;
      err      <= ERR_NONE;
    end else begin
      rd_req <= 1'b0;
      done   <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          target_q <= target_id;
          found    <= 1'b0;
          offset   <= '0;
          err      <= ERR_NONE;
          rd_req   <= 1'b1;
          rd_addr  <= A_STAT;
          state    <= S_STAT;
        end
        S_STAT: if (rd_valid) begin
          if (!rd_data[STAT_BIT]) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            rd_req  <= 1'b1;
            rd_addr <= A_HEAD;
            state   <= S_PTR;
          end
        end
        S_PTR: if (rd_valid) begin
          if (p_end) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (p_bad) begin
            err   <= ERR_BAD;
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (at_limit) begin
            err   <= ERR_LOOP;
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            cur     <= p_masked;
            rd_req  <= 1'b1;
            rd_addr <= p_masked;
            state   <= S_ID;
          end
        end
        S_ID: if (rd_valid) begin
          if (rd_data == target_q) begin
            found  <= 1'b1;
            offset <= cur;
            done   <= 1'b1;
            state  <= S_IDLE;
          end else begin
            rd_req  <= 1'b1;
            rd_addr <= cur + AW'(1);
            state   <= S_PTR;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: end-of-walk strobe lasts a single cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: results stay put while no new walk starts
  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !start) |=> ($stable(found) && $stable(offset) && $stable(err)));

  // R9: the latched target cannot change during a walk
  a_r9_target_hold: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |=> $stable(target_q));

  // R4: a reported match always lies at an aligned legal offset
  a_r4_found_offset: assert property (@(posedge clk) disable iff (rst)
    (done && found) |-> (offset >= AW'(MIN_PTR) && offset[RSVD_BITS-1:0] == '0));

  // R6: a match and an error are never reported together
  a_r6_excl: assert property (@(posedge clk) disable iff (rst)
    done |-> !(found && err != ERR_NONE));

  // R2: each read request is a single-cycle strobe
  a_r2_req_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
endmodule

// File: tb/sim_cap_walker.sv
module sim_cap_walker;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] target_id = '0;
  logic       rd_req;
  logic [7:0] rd_addr;
  logic       rd_valid = 1'b0;
  logic [7:0] rd_data = '0;
  logic       done, found;
  logic [7:0] offset;
  logic [1:0] err;

  logic [7:0] cfg [256];
  int         lat = 1;
  int         wcnt = 0;
  logic [7:0] pa = '0;
  int         nreads = 0;
  int         ndone = 0;
  int         checks = 0;
  int         fails = 0;
  logic       r_found;
  logic [7:0] r_off;
  logic [1:0] r_err;

  always #2.5 clk = ~clk;

  cap_walker u0 (
    .clk(clk), .rst(rst), .start(start), .target_id(target_id),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .found(found), .offset(offset), .err(err)
  );

  always @(posedge clk) begin
    rd_valid <= 1'b0;
    if (rst) begin
      wcnt <= 0;
    end else if (rd_req) begin
      pa     <= rd_addr;
      wcnt   <= lat;
      nreads <= nreads + 1;
    end else if (wcnt != 0) begin
      wcnt <= wcnt - 1;
      if (wcnt == 1) begin
        rd_valid <= 1'b1;
        rd_data  <= cfg[pa];
      end
    end
    if (done) ndone <= ndone + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic img_clear(input bit cap_on);
    for (int i = 0; i < 256; i++) cfg[i] = 8'h00;
    cfg[8'h06] = cap_on ? 8'h10 : 8'hEF;
  endtask

  task automatic walk(input logic [7:0] id);
    int t;
    @(negedge clk);
    nreads    = 0;
    target_id = id;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 5000, "R8 walk ends", t, 0);
    r_found = found;
    r_off   = offset;
    r_err   = err;
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
    chk(found == r_found && offset == r_off && err == r_err, "R8 results held",
        {found, offset, err}, {r_found, r_off, r_err});
  endtask

  task automatic t_reset;
    chk(done == 0 && found == 0 && rd_req == 0, "R1 reset flags", {done, found, rd_req}, 0);
    chk(err == 2'b00 && offset == 8'h00, "R1 reset values", {err, offset}, 0);
  endtask

  task automatic t_no_list;
    img_clear(1'b0);
    cfg[8'h34] = 8'h40; cfg[8'h40] = 8'h01;
    walk(8'h01);
    chk(r_found == 0 && r_err == 2'b00, "R2 no list result", {r_found, r_err}, 0);
    chk(nreads == 1, "R2 single read", nreads, 1);
  endtask

  task automatic t_chain;
    img_clear(1'b1);
    cfg[8'h34] = 8'h40;
    cfg[8'h40] = 8'h01; cfg[8'h41] = 8'h58;
    cfg[8'h58] = 8'h05; cfg[8'h59] = 8'h80;
    cfg[8'h80] = 8'h07; cfg[8'h81] = 8'h00;
    walk(8'h01);
    chk(r_found && r_off == 8'h40 && r_err == 0, "R4 id 0x01", r_off, 8'h40);
    walk(8'h05);
    chk(r_found && r_off == 8'h58 && r_err == 0, "R4 id 0x05", r_off, 8'h58);
    lat = 4;
    walk(8'h07);
    chk(r_found && r_off == 8'h80 && r_err == 0, "R4 id 0x07 slow port", r_off, 8'h80);
    lat = 1;
    walk(8'h09);
    chk(!r_found && r_err == 0 && r_off == 0, "R5 end of chain", {r_found, r_err, r_off}, 0);
  endtask

  task automatic t_mask;
    img_clear(1'b1);
    cfg[8'h34] = 8'h47;
    cfg[8'h44] = 8'h11; cfg[8'h45] = 8'h63;
    cfg[8'h60] = 8'h07; cfg[8'h61] = 8'h02;
    walk(8'h11);
    chk(r_found && r_off == 8'h44, "R3 head masked", r_off, 8'h44);
    walk(8'h07);
    chk(r_found && r_off == 8'h60, "R3 next masked", r_off, 8'h60);
    walk(8'h33);
    chk(!r_found && r_err == 2'b00, "R5 pointer masks to zero", {r_found, r_err}, 0);
  endtask

  task automatic t_bad;
    img_clear(1'b1);
    cfg[8'h34] = 8'h10;
    walk(8'h01);
    chk(!r_found && r_err == 2'b01, "R6 bad head", r_err, 1);
    cfg[8'h34] = 8'h40; cfg[8'h40] = 8'h09; cfg[8'h41] = 8'h3C;
    walk(8'h01);
    chk(!r_found && r_err == 2'b01, "R6 bad next", r_err, 1);
  endtask

  task automatic t_loop;
    img_clear(1'b1);
    cfg[8'h34] = 8'h40; cfg[8'h40] = 8'h09; cfg[8'h41] = 8'h40;
    walk(8'h01);
    chk(!r_found && r_err == 2'b10, "R7 self loop", r_err, 2);
    img_clear(1'b1);
    cfg[8'h34] = 8'h40;
    for (int i = 0; i < 48; i++) begin
      cfg[8'h40 + 4*i]     = 8'h20;
      cfg[8'h40 + 4*i + 1] = (i == 47) ? 8'h00 : 8'(8'h44 + 4*i);
    end
    cfg[8'hFC] = 8'h07;
    walk(8'h07);
    chk(r_found && r_off == 8'hFC && r_err == 0, "R7 48 blocks found", r_off, 8'hFC);
    walk(8'h55);
    chk(!r_found && r_err == 0, "R7 48 blocks no match", r_err, 0);
  endtask

  task automatic t_busy;
    int d0;
    img_clear(1'b1);
    cfg[8'h34] = 8'h40;
    cfg[8'h40] = 8'h05; cfg[8'h41] = 8'h50;
    cfg[8'h50] = 8'h01; cfg[8'h51] = 8'h00;
    lat = 3;
    d0 = ndone;
    @(negedge clk);
    target_id = 8'h01; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    target_id = 8'h05; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    chk(ndone - d0 == 1, "R9 one done only", ndone - d0, 1);
    chk(found && offset == 8'h50, "R9 first target kept", offset, 8'h50);
    lat = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_no_list();
    t_chain();
    t_mask();
    t_bad();
    t_loop();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule